// File: doc/BRIEF.md
# PCS Loopback and Idle-Insertion Controller

This block sits between the transmit and receive code-group paths of a 1000BASE-X PCS and a serial transceiver. It has two loopback points. At the PCS point, the PCS transmit code groups are turned straight back into the PCS receive input just before the transceiver. The transceiver transmit lane then carries only a continuous idle ordered set, so the link partner stays in sync but never sees a test frame. At the transceiver point, the block raises a loopback request to the transceiver. Normal transmit data keeps leaving the device, and the receive path takes whatever the transceiver returns.

A small management register file sets up the block. It holds the loopback enable, the loopback point select, and an auto-negotiation interrupt with an enable and a sticky pending flag. The status register shows the live auto-negotiation-complete input.

A loopback change only takes effect on an even code-group boundary. The receive side therefore never sees half an ordered set.

Top module: `pcs_lpbk_ctrl`

## Requirements
- R1: After reset the registers read as zero and `an_irq` is 0. Loopback is off, which means `xcvr_lpbk_req` is 0, `line_tx_cg` equals `pcs_tx_cg`, and `pcs_rx_cg` equals `xcvr_rx_cg`.
- R2: With loopback off, `line_tx_cg` follows `pcs_tx_cg` and `pcs_rx_cg` follows `xcvr_rx_cg` in the same cycle, and `xcvr_lpbk_req` is 0.
- R3: In PCS-point loopback, `pcs_rx_cg` equals `pcs_tx_cg`. `line_tx_cg` carries 10'h0FA (K28.5) in cycles with `tx_even`=1 and 10'h245 (D16.2) in cycles with `tx_even`=0. `xcvr_lpbk_req` is 0.
- R4: In transceiver-point loopback, `xcvr_lpbk_req` is 1, `line_tx_cg` equals `pcs_tx_cg`, and `pcs_rx_cg` equals `xcvr_rx_cg`.
- R5: Address 0 bit 14 enables loopback. Address 4 bit 0 selects the point: 0 for PCS, 1 for transceiver. Both read back, and all other bits of both read as 0.
- R6: The active loopback mode changes only at a clock edge that ends a cycle with `tx_even`=0. The first cycle in the new mode therefore has `tx_even`=1. Register values written earlier apply at the first such edge.
- R7: A read of address 1 returns `an_done`, as sampled in the read cycle, in bit 5, with all other bits 0.
- R8: Address 2 bit 1 is a pending flag. A rising edge of `an_done` sets it. Writing 1 to bit 1 clears it, and writing 0 leaves it unchanged. If a rising edge and a clearing write fall in the same cycle, the flag ends up set.
- R9: Address 2 bit 0 is a read/write interrupt enable. `an_irq` is the AND of the pending flag and the enable.
- R10: Read data appears on `mgmt_rdata` in the cycle after `mgmt_rd` and is zero in a cycle that follows no read. A read that coincides with a write returns the value from before the write. Writes to addresses other than 0, 2 and 4 are ignored, and reads of addresses other than 0, 1, 2 and 4 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Code-group clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pcs_tx_cg | input | 10 | Code group from the PCS transmitter |
| tx_even | input | 1 | High when the current code group is at an even position |
| line_tx_cg | output | 10 | Code group to the transceiver transmitter |
| xcvr_rx_cg | input | 10 | Code group from the transceiver receiver |
| pcs_rx_cg | output | 10 | Code group to the PCS receiver |
| xcvr_lpbk_req | output | 1 | Asks the transceiver to loop internally |
| an_done | input | 1 | Auto-negotiation complete |
| an_irq | output | 1 | Auto-negotiation interrupt |
| mgmt_addr | input | 5 | Register address |
| mgmt_wr | input | 1 | Write strobe |
| mgmt_rd | input | 1 | Read strobe |
| mgmt_wdata | input | 16 | Write data |
| mgmt_rdata | output | 16 | Read data, one cycle after the read strobe |

## Verification
Two pairs of events can land in the same cycle. The first pair is a rising edge of `an_done` and a write that clears the pending flag. The second pair is a write that changes the loopback setting and the even/odd boundary on which the mode switch is allowed.

The bench forces the first collision directly, then keeps producing both collisions with random writes, random reads and random toggling of `an_done` over a long run. Every cycle it compares the datapath outputs, the interrupt and the read data against a model built from the requirements. It judges the mode switch by the exact cycle in which the outputs change, checked against the parity of `tx_even`.

// File: rtl/pcs_lpbk_pkg.sv
package pcs_lpbk_pkg;
    localparam int CG_W   = 10;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;

    // register addresses
    localparam int A_CTRL  = 0;
    localparam int A_STAT  = 1;
    localparam int A_ANIRQ = 2;
    localparam int A_LPSEL = 4;

    // bit positions
    localparam int B_LPEN    = 14;
    localparam int B_ANDONE  = 5;
    localparam int B_IRQEN   = 0;
    localparam int B_IRQPEND = 1;
    localparam int B_LPPT    = 0;

    // idle ordered set /I2/
    localparam logic [9:0] CG_K285 = 10'h0FA;
    localparam logic [9:0] CG_D162 = 10'h245;

    typedef enum logic [1:0] {
        LB_OFF  = 2'd0,
        LB_PCS  = 2'd1,
        LB_XCVR = 2'd2
    } lb_mode_e;
endpackage

// File: rtl/pcs_lpbk_regs.sv
module pcs_lpbk_regs
    import pcs_lpbk_pkg::*;
#(
    parameter int ADDR_W = pcs_lpbk_pkg::ADDR_W,
    parameter int DATA_W = pcs_lpbk_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              an_done,
    output logic              lp_en,
    output logic              lp_pt,
    output logic              irq
);
    typedef struct packed {
        logic              lp_en;
        logic              lp_pt;
        logic              irq_en;
        logic              irq_pend;
        logic              an_prev;
        logic [DATA_W-1:0] rdata;
    } regs_st_t;

    regs_st_t s_d, s_q;
    logic [DATA_W-1:0] rd_val;
    logic wr_ctrl, wr_irq, wr_sel;
    logic unused_wbits;

    assign unused_wbits = ^wdata;

    always_comb begin
        wr_ctrl = wr && (addr == ADDR_W'(A_CTRL));
        wr_irq  = wr && (addr == ADDR_W'(A_ANIRQ));
        wr_sel  = wr && (addr == ADDR_W'(A_LPSEL));

        rd_val = '0;
        if (addr == ADDR_W'(A_CTRL)) begin
            rd_val[B_LPEN] = s_q.lp_en;
        end else if (addr == ADDR_W'(A_STAT)) begin
            rd_val[B_ANDONE] = an_done;
        end else if (addr == ADDR_W'(A_ANIRQ)) begin
            rd_val[B_IRQEN]   = s_q.irq_en;
            rd_val[B_IRQPEND] = s_q.irq_pend;
        end else if (addr == ADDR_W'(A_LPSEL)) begin
            rd_val[B_LPPT] = s_q.lp_pt;
        end

        s_d         = s_q;
        s_d.an_prev = an_done;
        if (wr_ctrl) s_d.lp_en = wdata[B_LPEN];
        if (wr_sel)  s_d.lp_pt = wdata[B_LPPT];
        if (wr_irq) begin
            s_d.irq_en = wdata[B_IRQEN];
            if (wdata[B_IRQPEND]) s_d.irq_pend = 1'b0;
        end
        // a new completion edge wins over a same-cycle clear
        if (an_done && !s_q.an_prev) s_d.irq_pend = 1'b1;
        s_d.rdata = rd ? rd_val : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdata = s_q.rdata;
    assign lp_en = s_q.lp_en;
    assign lp_pt = s_q.lp_pt;
    assign irq   = s_q.irq_pend & s_q.irq_en;
endmodule

// File: rtl/pcs_lpbk_path.sv
module pcs_lpbk_path
    import pcs_lpbk_pkg::*;
#(
    parameter int CG_W = pcs_lpbk_pkg::CG_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lp_en,
    input  logic            lp_pt,
    input  logic [CG_W-1:0] tx_cg,
    input  logic            tx_even,
    input  logic [CG_W-1:0] xcvr_rx,
    output logic [CG_W-1:0] line_tx,
    output logic [CG_W-1:0] rx_cg,
    output logic            lpbk_req
);
    typedef struct packed {
        lb_mode_e mode;
    } path_st_t;

    path_st_t s_d, s_q;
    lb_mode_e want;
    logic [CG_W-1:0] idle_cg;

    always_comb begin
        if (!lp_en)     want = LB_OFF;
        else if (lp_pt) want = LB_XCVR;
        else            want = LB_PCS;

        s_d = s_q;
        // switch only when the next code group starts an ordered set
        if (!tx_even) s_d.mode = want;

        idle_cg = tx_even ? CG_W'(CG_K285) : CG_W'(CG_D162);

        line_tx  = tx_cg;
        rx_cg    = xcvr_rx;
        lpbk_req = 1'b0;
        case (s_q.mode)
            LB_PCS: begin
                line_tx = idle_cg;
                rx_cg   = tx_cg;
            end
            LB_XCVR: lpbk_req = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{mode: LB_OFF};
        else        s_q <= s_d;
    end
endmodule

// File: rtl/pcs_lpbk_ctrl.sv
module pcs_lpbk_ctrl
    import pcs_lpbk_pkg::*;
#(
    parameter int CG_W   = pcs_lpbk_pkg::CG_W,
    parameter int ADDR_W = pcs_lpbk_pkg::ADDR_W,
    parameter int DATA_W = pcs_lpbk_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CG_W-1:0]   pcs_tx_cg,
    input  logic              tx_even,
    output logic [CG_W-1:0]   line_tx_cg,
    input  logic [CG_W-1:0]   xcvr_rx_cg,
    output logic [CG_W-1:0]   pcs_rx_cg,
    output logic              xcvr_lpbk_req,
    input  logic              an_done,
    output logic              an_irq,
    input  logic [ADDR_W-1:0] mgmt_addr,
    input  logic              mgmt_wr,
    input  logic              mgmt_rd,
    input  logic [DATA_W-1:0] mgmt_wdata,
    output logic [DATA_W-1:0] mgmt_rdata
);
    logic lp_en, lp_pt;

    pcs_lpbk_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (mgmt_addr),
        .wr      (mgmt_wr),
        .rd      (mgmt_rd),
        .wdata   (mgmt_wdata),
        .rdata   (mgmt_rdata),
        .an_done (an_done),
        .lp_en   (lp_en),
        .lp_pt   (lp_pt),
        .irq     (an_irq)
    );

    pcs_lpbk_path #(.CG_W(CG_W)) u_path (
        .clk      (clk),
        .rst_n    (rst_n),
        .lp_en    (lp_en),
        .lp_pt    (lp_pt),
        .tx_cg    (pcs_tx_cg),
        .tx_even  (tx_even),
        .xcvr_rx  (xcvr_rx_cg),
        .line_tx  (line_tx_cg),
        .rx_cg    (pcs_rx_cg),
        .lpbk_req (xcvr_lpbk_req)
    );
endmodule

// File: rtl/pcs_lpbk_ctrl_chk.sv
module pcs_lpbk_ctrl_chk
    import pcs_lpbk_pkg::*;
#(
    parameter int CG_W   = pcs_lpbk_pkg::CG_W,
    parameter int ADDR_W = pcs_lpbk_pkg::ADDR_W,
    parameter int DATA_W = pcs_lpbk_pkg::DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CG_W-1:0]   pcs_tx_cg,
    input logic              tx_even,
    input logic [CG_W-1:0]   line_tx_cg,
    input logic [CG_W-1:0]   xcvr_rx_cg,
    input logic [CG_W-1:0]   pcs_rx_cg,
    input logic              xcvr_lpbk_req,
    input logic              an_done,
    input logic              an_irq,
    input logic [ADDR_W-1:0] mgmt_addr,
    input logic              mgmt_wr,
    input logic              mgmt_rd,
    input logic [DATA_W-1:0] mgmt_wdata,
    input logic [DATA_W-1:0] mgmt_rdata
);
    // R3
    idle_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_tx_cg != pcs_tx_cg) |->
            (line_tx_cg == (tx_even ? CG_W'(CG_K285) : CG_W'(CG_D162))));

    // R3
    pcs_loop_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_tx_cg != pcs_tx_cg) |-> (pcs_rx_cg == pcs_tx_cg && !xcvr_lpbk_req));

    // R4
    xcvr_loop_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xcvr_lpbk_req |-> (line_tx_cg == pcs_tx_cg && pcs_rx_cg == xcvr_rx_cg));

    // R6
    even_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(xcvr_lpbk_req) |-> tx_even);

    // R8
    irq_clear_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(an_irq) |-> $past(mgmt_wr));

    // R9
    irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(an_irq) |-> ($past(mgmt_wr) || $past(an_done)));

    // R10
    rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mgmt_rd |=> (mgmt_rdata == '0));
endmodule

bind pcs_lpbk_ctrl pcs_lpbk_ctrl_chk #(.CG_W(CG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/pcs_lpbk_ctrl_test.sv
`timescale 1ns/1ps
module pcs_lpbk_ctrl_test;
    localparam logic [9:0] K285 = 10'h0FA;
    localparam logic [9:0] D162 = 10'h245;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  pcs_tx_cg = '0, xcvr_rx_cg = '0;
    logic        tx_even = 1'b1;
    logic [9:0]  line_tx_cg, pcs_rx_cg;
    logic        xcvr_lpbk_req, an_irq;
    logic        an_done = 1'b0;
    logic [4:0]  mgmt_addr = '0;
    logic        mgmt_wr = 1'b0, mgmt_rd = 1'b0;
    logic [15:0] mgmt_wdata = '0;
    logic [15:0] mgmt_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    bit m_en, m_pt, m_ien, m_pend, m_prev;
    int m_mode, last_mode;
    logic [15:0] m_rdata;
    string m_rtag;
    bit even_v;

    always #2.5 clk = ~clk;

    pcs_lpbk_ctrl uut (
        .clk(clk), .rst_n(rst_n), .pcs_tx_cg(pcs_tx_cg), .tx_even(tx_even),
        .line_tx_cg(line_tx_cg), .xcvr_rx_cg(xcvr_rx_cg), .pcs_rx_cg(pcs_rx_cg),
        .xcvr_lpbk_req(xcvr_lpbk_req), .an_done(an_done), .an_irq(an_irq),
        .mgmt_addr(mgmt_addr), .mgmt_wr(mgmt_wr), .mgmt_rd(mgmt_rd),
        .mgmt_wdata(mgmt_wdata), .mgmt_rdata(mgmt_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] read_val(input logic [4:0] a, input bit an);
        logic [15:0] v = '0;
        case (a)
            5'd0: v[14] = m_en;
            5'd1: v[5]  = an;
            5'd2: begin v[0] = m_ien; v[1] = m_pend; end
            5'd4: v[0] = m_pt;
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic string read_tag(input logic [4:0] a);
        case (a)
            5'd0, 5'd4: return "R5";
            5'd1:       return "R7";
            5'd2:       return "R8";
            default:    return "R10";
        endcase
    endfunction

    // one cycle: drive, check outputs of current state, then advance model
    task automatic cyc(input logic [4:0] a, input bit wr, input bit rd,
                       input logic [15:0] wd, input bit an);
        string dtag;
        logic [9:0] tx, xr;
        @(negedge clk);
        tx = 10'($urandom); xr = 10'($urandom);
        pcs_tx_cg = tx; xcvr_rx_cg = xr; tx_even = even_v;
        mgmt_addr = a; mgmt_wr = wr; mgmt_rd = rd; mgmt_wdata = wd; an_done = an;
        #1;
        dtag = (m_mode == 1) ? "R3" : (m_mode == 2) ? "R4" : "R2";
        if (m_mode != last_mode) dtag = "R6";
        last_mode = m_mode;
        chk(dtag, line_tx_cg, (m_mode == 1) ? (even_v ? K285 : D162) : tx);
        chk(dtag, pcs_rx_cg,  (m_mode == 1) ? tx : xr);
        chk(dtag, xcvr_lpbk_req, m_mode == 2);
        chk("R9", an_irq, m_pend & m_ien);
        chk(m_rtag, mgmt_rdata, m_rdata);
        @(posedge clk);
        if (!even_v) m_mode = m_en ? (m_pt ? 2 : 1) : 0;
        m_rdata = rd ? read_val(a, an) : 16'h0;
        m_rtag  = rd ? read_tag(a) : "R10";
        if (wr) begin
            if (a == 5'd0) m_en = wd[14];
            if (a == 5'd4) m_pt = wd[0];
            if (a == 5'd2) begin
                m_ien = wd[0];
                if (wd[1]) m_pend = 1'b0;
            end
        end
        if (an && !m_prev) m_pend = 1'b1;
        m_prev = an;
        even_v = ~even_v;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit an_v;
        void'($urandom(32'd4242));
        m_en = 0; m_pt = 0; m_ien = 0; m_pend = 0; m_prev = 0;
        m_mode = 0; last_mode = 0; m_rdata = '0; m_rtag = "R1"; even_v = 1;
        an_v = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", xcvr_lpbk_req, 0);
        chk("R1", an_irq, 0);
        chk("R1", mgmt_rdata, 0);
        chk("R1", line_tx_cg, pcs_tx_cg);
        chk("R1", pcs_rx_cg, xcvr_rx_cg);
        // R1 / R10: every address reads zero after reset
        for (int a = 0; a < 32; a++) cyc(5'(a), 0, 1, '0, 0);
        // R2 pass-through
        repeat (4) cyc(5'd1, 0, 0, '0, 0);
        // R5: enable PCS loopback, writing an odd cycle then idle
        cyc(5'd0, 1, 0, 16'hFFFF, 0);
        cyc(5'd0, 0, 1, '0, 0);
        repeat (8) cyc(5'd3, 0, 0, '0, 0);
        // R4: switch to transceiver point
        cyc(5'd4, 1, 0, 16'hFFFF, 0);
        cyc(5'd4, 0, 1, '0, 0);
        repeat (6) cyc(5'd3, 0, 0, '0, 0);
        // R10: unused addresses ignore writes
        cyc(5'd3, 1, 0, 16'hFFFF, 0);
        cyc(5'd31, 1, 0, 16'hFFFF, 0);
        cyc(5'd3, 0, 1, '0, 0);
        cyc(5'd0, 0, 1, '0, 0);
        cyc(5'd4, 0, 1, '0, 0);
        // R7 status reflects an_done
        cyc(5'd1, 0, 1, '0, 1);
        cyc(5'd1, 0, 1, '0, 1);
        // R9 enable, then R8 clear
        cyc(5'd2, 1, 1, 16'h0001, 1);
        cyc(5'd2, 0, 1, '0, 0);
        cyc(5'd2, 1, 0, 16'h0003, 0);
        cyc(5'd2, 0, 1, '0, 0);
        // R8: rising edge and clearing write in the same cycle, set wins
        cyc(5'd2, 1, 0, 16'h0003, 1);
        cyc(5'd2, 0, 1, '0, 1);
        cyc(5'd2, 1, 0, 16'h0001, 0);
        cyc(5'd2, 0, 1, '0, 0);
        // loopback off
        cyc(5'd0, 1, 0, 16'h0000, 0);
        repeat (3) cyc(5'd0, 0, 0, '0, 0);
        // random phase
        an_v = 0;
        for (int i = 0; i < 4000; i++) begin
            logic [4:0] a;
            int pick = $urandom_range(0, 6);
            a = (pick < 5) ? 5'(pick) : 5'($urandom);
            if ($urandom_range(0, 15) == 0) an_v = ~an_v;
            cyc(a, $urandom_range(0, 5) == 0, $urandom_range(0, 3) == 0,
                16'($urandom), an_v);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule